// File: doc/BRIEF.md
# MD5 Block Compression Engine

This engine folds one 512-bit message block into a 128-bit chaining value using the MD5 compression function. The caller presents the current four 32-bit chaining words and a 64-byte block that has already been padded. A one-cycle start pulse loads them. The engine then performs one of the 64 steps on each clock, spread over four rounds, and finally adds the saved input words back in to form the new chaining value.

A longer message is hashed by running blocks back to back. Each result is fed in as the chaining input for the next block. Padding, length encoding, the choice of initial value and any bus attachment are the caller's concern.

Chaining words are packed with word A in bits 31:0, B in 63:32, C in 95:64 and D in 127:96. Message byte j occupies bits 8j+7:8j of the block input.

Top module: `md5c_core`

## Requirements
- R1: Message word k (0..15) is assembled little-endian from bytes 4k..4k+3, with byte 4k in bits 7:0 of the word.
- R2: Each step i computes b + rotl32(a + f(b,c,d) + K[i] + M[g], s) with modulo-2^32 adds, and the roles then move so that (a,b,c,d) becomes (d, new, b, c). The four rounds are defined as follows. Round 1: f = (b&c)|(~b&d), g = i, rotations 7/12/17/22. Round 2: f = (b&d)|(c&~d), g = (5i+1) mod 16, rotations 5/9/14/20. Round 3: f = b^c^d, g = (3i+5) mod 16, rotations 4/11/16/23. Round 4: f = c^(b|~d), g = 7i mod 16, rotations 6/10/15/21. K[i] is floor(|sin(i+1)| * 2^32).
- R3: After the last step, each input chaining word saved at load time is added modulo 2^32 to its working word, and the sums form state_out.
- R4: A start pulse while busy is low loads state_in and block_in. busy then rises on the next clock and stays high for exactly 64 cycles.
- R5: done is high for exactly one cycle, in the cycle that follows the final busy cycle. busy is low in that cycle, and state_out already holds the new result.
- R6: A start pulse while busy is high is ignored. The running computation and its result are unaffected.
- R7: state_out changes only in a cycle where done is high, and it holds its value in all other cycles.
- R8: After reset, busy and done are low and state_out is zero.
- R9: Starting from the chaining value 0x67452301, 0xefcdab89, 0x98badcfe, 0x10325476, the padded empty message gives the digest d41d8cd98f00b204e9800998ecf8427e. The padded message "abc" gives 900150983cd24fb0d6963f7d28e17f72. In both cases the digest bytes are state_out bytes 0..15 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load inputs and begin when idle |
| state_in | input | 128 | Chaining input {D,C,B,A} |
| block_in | input | 512 | Padded block, byte j at bits 8j+7:8j |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle result strobe |
| state_out | output | 128 | Chaining result {D,C,B,A} |

## Verification
The algorithm fixes every width, so the engine is built only with the constants of its package: 32-bit words, 16 message words and 64 steps. The bench therefore exercises the complete four-round schedule and all 64 additive constants on every run. It pairs the two known digests with random blocks and random chaining inputs, and it compares each result against a software model that derives its constants from the sine formula. Chained runs, starts issued back to back in the done cycle, and start pulses issued mid-run reach the handshake corners.

// File: rtl/md5c_pkg.sv
package md5c_pkg;

    localparam int WORD_W  = 32;
    localparam int NWORDS  = 16;
    localparam int NSTEPS  = 64;
    localparam int STEP_W  = $clog2(NSTEPS);
    localparam int WIDX_W  = $clog2(NWORDS);
    localparam int STATE_W = 4 * WORD_W;
    localparam int BLOCK_W = NWORDS * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STEP_W-1:0] step_t;

    // Word a sits in the low bits so a cast of {D,C,B,A} lines up.
    typedef struct packed {
        word_t d;
        word_t c;
        word_t b;
        word_t a;
    } md5_state_t;

    function automatic word_t rotl(input word_t x, input logic [4:0] s);
        return (x << s) | (x >> (6'd32 - {1'b0, s}));
    endfunction

    function automatic word_t mix_fn(input logic [1:0] rnd, input word_t b,
                                     input word_t c, input word_t d);
        case (rnd)
            2'd0:    return (b & c) | (~b & d);
            2'd1:    return (b & d) | (c & ~d);
            2'd2:    return b ^ c ^ d;
            default: return c ^ (b | ~d);
        endcase
    endfunction

    function automatic logic [WIDX_W-1:0] msg_index(input step_t i);
        logic [WIDX_W-1:0] j;
        j = i[WIDX_W-1:0];
        case (i[STEP_W-1:STEP_W-2])
            2'd0:    return j;
            2'd1:    return WIDX_W'(5 * j + 1);
            2'd2:    return WIDX_W'(3 * j + 5);
            default: return WIDX_W'(7 * j);
        endcase
    endfunction

    function automatic logic [4:0] shift_amt(input step_t i);
        case ({i[STEP_W-1:STEP_W-2], i[1:0]})
            4'h0: return 5'd7;   4'h1: return 5'd12;
            4'h2: return 5'd17;  4'h3: return 5'd22;
            4'h4: return 5'd5;   4'h5: return 5'd9;
            4'h6: return 5'd14;  4'h7: return 5'd20;
            4'h8: return 5'd4;   4'h9: return 5'd11;
            4'hA: return 5'd16;  4'hB: return 5'd23;
            4'hC: return 5'd6;   4'hD: return 5'd10;
            4'hE: return 5'd15;  default: return 5'd21;
        endcase
    endfunction

    function automatic word_t step_const(input step_t i);
        case (i)
            6'd0:  return 32'hd76aa478;  6'd1:  return 32'he8c7b756;
            6'd2:  return 32'h242070db;  6'd3:  return 32'hc1bdceee;
            6'd4:  return 32'hf57c0faf;  6'd5:  return 32'h4787c62a;
            6'd6:  return 32'ha8304613;  6'd7:  return 32'hfd469501;
            6'd8:  return 32'h698098d8;  6'd9:  return 32'h8b44f7af;
            6'd10: return 32'hffff5bb1;  6'd11: return 32'h895cd7be;
            6'd12: return 32'h6b901122;  6'd13: return 32'hfd987193;
            6'd14: return 32'ha679438e;  6'd15: return 32'h49b40821;
            6'd16: return 32'hf61e2562;  6'd17: return 32'hc040b340;
            6'd18: return 32'h265e5a51;  6'd19: return 32'he9b6c7aa;
            6'd20: return 32'hd62f105d;  6'd21: return 32'h02441453;
            6'd22: return 32'hd8a1e681;  6'd23: return 32'he7d3fbc8;
            6'd24: return 32'h21e1cde6;  6'd25: return 32'hc33707d6;
            6'd26: return 32'hf4d50d87;  6'd27: return 32'h455a14ed;
            6'd28: return 32'ha9e3e905;  6'd29: return 32'hfcefa3f8;
            6'd30: return 32'h676f02d9;  6'd31: return 32'h8d2a4c8a;
            6'd32: return 32'hfffa3942;  6'd33: return 32'h8771f681;
            6'd34: return 32'h6d9d6122;  6'd35: return 32'hfde5380c;
            6'd36: return 32'ha4beea44;  6'd37: return 32'h4bdecfa9;
            6'd38: return 32'hf6bb4b60;  6'd39: return 32'hbebfbc70;
            6'd40: return 32'h289b7ec6;  6'd41: return 32'heaa127fa;
            6'd42: return 32'hd4ef3085;  6'd43: return 32'h04881d05;
            6'd44: return 32'hd9d4d039;  6'd45: return 32'he6db99e5;
            6'd46: return 32'h1fa27cf8;  6'd47: return 32'hc4ac5665;
            6'd48: return 32'hf4292244;  6'd49: return 32'h432aff97;
            6'd50: return 32'hab9423a7;  6'd51: return 32'hfc93a039;
            6'd52: return 32'h655b59c3;  6'd53: return 32'h8f0ccc92;
            6'd54: return 32'hffeff47d;  6'd55: return 32'h85845dd1;
            6'd56: return 32'h6fa87e4f;  6'd57: return 32'hfe2ce6e0;
            6'd58: return 32'ha3014314;  6'd59: return 32'h4e0811a1;
            6'd60: return 32'hf7537e82;  6'd61: return 32'hbd3af235;
            6'd62: return 32'h2ad7d2bb;  default: return 32'heb86d391;
        endcase
    endfunction

endpackage

// File: rtl/md5c_ctrl.sv
module md5c_ctrl
    import md5c_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  busy,
    output logic  load,
    output logic  last,
    output step_t step
);

    assign load = start && !busy;
    assign last = busy && (step == step_t'(NSTEPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            step <= '0;
        end else if (load) begin
            busy <= 1'b1;
            step <= '0;
        end else if (busy) begin
            step <= step + 1'b1;
            if (last) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/md5c_msgsel.sv
module md5c_msgsel
    import md5c_pkg::*;
(
    input  logic [BLOCK_W-1:0] blk,
    input  step_t              step,
    output word_t              mword
);

    logic [WIDX_W-1:0] idx;

    assign idx   = msg_index(step);
    assign mword = blk[{idx, 5'b0} +: WORD_W];

endmodule

// File: rtl/md5c_step.sv
module md5c_step
    import md5c_pkg::*;
(
    input  md5_state_t cur,
    input  step_t      step,
    input  word_t      mword,
    output md5_state_t nxt
);

    word_t pre;
    word_t fresh;

    always_comb begin
        pre   = cur.a + mix_fn(step[STEP_W-1:STEP_W-2], cur.b, cur.c, cur.d)
              + step_const(step) + mword;
        fresh = cur.b + rotl(pre, shift_amt(step));
        nxt.a = cur.d;
        nxt.b = fresh;
        nxt.c = cur.b;
        nxt.d = cur.c;
    end

endmodule

// File: rtl/md5c_core.sv
module md5c_core
    import md5c_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [STATE_W-1:0]  state_in,
    input  logic [BLOCK_W-1:0]  block_in,
    output logic                busy,
    output logic                done,
    output logic [STATE_W-1:0]  state_out
);

    logic               load;
    logic               last;
    step_t              step;
    word_t              mword;
    md5_state_t         work;
    md5_state_t         saved;
    md5_state_t         nxt;
    md5_state_t         result;
    logic [BLOCK_W-1:0] blk;

    md5c_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .busy (busy),
        .load (load),
        .last (last),
        .step (step)
    );

    md5c_msgsel u_msgsel (
        .blk  (blk),
        .step (step),
        .mword(mword)
    );

    md5c_step u_step (
        .cur  (work),
        .step (step),
        .mword(mword),
        .nxt  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            saved  <= '0;
            blk    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                work  <= md5_state_t'(state_in);
                saved <= md5_state_t'(state_in);
                blk   <= block_in;
            end else if (busy) begin
                work <= nxt;
                if (last) begin
                    result.a <= saved.a + nxt.a;
                    result.b <= saved.b + nxt.b;
                    result.c <= saved.c + nxt.c;
                    result.d <= saved.d + nxt.d;
                    done     <= 1'b1;
                end
            end
        end
    end

    assign state_out = result;

endmodule

// File: rtl/md5c_chk.sv
module md5c_chk
    import md5c_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [STATE_W-1:0] state_out
);

    logic [STEP_W:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) bcnt <= '0;
        else              bcnt <= bcnt + 1'b1;
    end

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && (bcnt < (STEP_W+1)'(NSTEPS - 1)) |=> busy);

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy && (bcnt == (STEP_W+1)'(NSTEPS - 1)) |=> !busy);

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        busy && start && (bcnt < (STEP_W+1)'(NSTEPS - 1)) |=> busy && !done);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_out) |-> done);

    // R8
    reset_state_chk: assert property (@(posedge clk)
        rst |=> !busy && !done && (state_out == '0));

endmodule

bind md5c_core md5c_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .state_out(state_out)
);

// File: tb/md5c_core_bench.sv
`timescale 1ns/1ps
module md5c_core_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] state_in = '0;
    logic [511:0] block_in = '0;
    logic         busy;
    logic         done;
    logic [127:0] state_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    md5c_core u_md5c_core (
        .clk(clk), .rst(rst), .start(start), .state_in(state_in),
        .block_in(block_in), .busy(busy), .done(done), .state_out(state_out)
    );

    typedef struct { logic [127:0] val; string tag; } exp_t;
    exp_t sb[$];

    logic [31:0] ktab [64];
    int rtab [4][4] = '{'{7, 12, 17, 22}, '{5, 9, 14, 20},
                        '{4, 11, 16, 23}, '{6, 10, 15, 21}};

    localparam logic [127:0] IV = {32'h10325476, 32'h98badcfe, 32'hefcdab89, 32'h67452301};

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] byte_rev(input logic [127:0] h);
        logic [127:0] r;
        for (int j = 0; j < 16; j++) r[8*j +: 8] = h[127-8*j -: 8];
        return r;
    endfunction

    function automatic logic [127:0] ref_compress(input logic [127:0] st,
                                                  input logic [511:0] blk);
        logic [31:0] a, b, c, d, f, t, nb;
        int g, s;
        a = st[31:0]; b = st[63:32]; c = st[95:64]; d = st[127:96];
        for (int i = 0; i < 64; i++) begin
            case (i / 16)
                0: begin f = (b & c) | (~b & d); g = i; end
                1: begin f = (b & d) | (c & ~d); g = (5*i + 1) % 16; end
                2: begin f = b ^ c ^ d;          g = (3*i + 5) % 16; end
                default: begin f = c ^ (b | ~d); g = (7*i) % 16; end
            endcase
            s = rtab[i/16][i%4];
            t = a + f + ktab[i] + {blk[32*g+24 +: 8], blk[32*g+16 +: 8],
                                   blk[32*g+8 +: 8], blk[32*g +: 8]};
            t = (t << s) | (t >> (32 - s));
            nb = b + t;
            a = d; d = c; c = b; b = nb;
        end
        return {d + st[127:96], c + st[95:64], b + st[63:32], a + st[31:0]};
    endfunction

    task automatic run_block(input logic [127:0] st, input logic [511:0] blk,
                             input logic [127:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e.val = exp; e.tag = tag;
        sb.push_back(e);
        state_in = st; block_in = blk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: pop expected on done, then check done drops (R5)
    logic [127:0] last_out = '0;
    always @(posedge clk) begin
        #1;
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected result", state_out, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(state_out === e.val, {"R2 R3 ", e.tag}, state_out, e.val);
                check(busy === 1'b0, "R5 busy low with done", {127'b0, busy}, '0);
            end
            last_out = state_out;
            @(posedge clk);
            #1;
            check(done === 1'b0, "R5 done one cycle", {127'b0, done}, '0);
        end
    end

    // Busy length (R4) and output hold during a run (R7)
    int bcount = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                bcount++;
                if (bcount == 32)
                    check(state_out === last_out, "R7 hold during run", state_out, last_out);
            end else if (bcount != 0) begin
                check(bcount == 64, "R4 busy length", 128'(bcount), 128'd64);
                bcount = 0;
            end
        end
    end

    initial begin
        logic [511:0] blk_e, blk_abc, blk_r, blk_a2;
        logic [127:0] st_r, r1, hold_v;
        for (int i = 0; i < 64; i++) begin
            real v;
            v = $sin(real'(i + 1));
            if (v < 0.0) v = -v;
            ktab[i] = 32'(longint'($floor(v * 4294967296.0)));
        end

        repeat (3) @(negedge clk);
        // R8
        check(busy === 1'b0, "R8 busy after reset", {127'b0, busy}, '0);
        check(done === 1'b0, "R8 done after reset", {127'b0, done}, '0);
        check(state_out === '0, "R8 state_out after reset", state_out, '0);
        rst = 1'b0;

        // R9, R1: known digests
        blk_e = '0; blk_e[7:0] = 8'h80;
        blk_abc = '0;
        blk_abc[31:0] = 32'h80636261;
        blk_abc[455:448] = 8'h18;
        check(ref_compress(IV, blk_e) === byte_rev(128'hd41d8cd98f00b204e9800998ecf8427e),
              "R9 model empty", ref_compress(IV, blk_e),
              byte_rev(128'hd41d8cd98f00b204e9800998ecf8427e));
        run_block(IV, blk_e, byte_rev(128'hd41d8cd98f00b204e9800998ecf8427e), "R9 R1 empty");
        run_block(IV, blk_abc, byte_rev(128'h900150983cd24fb0d6963f7d28e17f72), "R9 R1 abc");
        wait_idle();

        // R3: chained blocks, result fed back as next input
        r1 = byte_rev(128'h900150983cd24fb0d6963f7d28e17f72);
        for (int k = 0; k < 3; k++) begin
            for (int w = 0; w < 16; w++) blk_r[32*w +: 32] = $urandom;
            run_block(r1, blk_r, ref_compress(r1, blk_r), "R3 chained");
            r1 = ref_compress(r1, blk_r);
        end

        // R2: random states and blocks, including all-zero and all-one
        for (int k = 0; k < 6; k++) begin
            for (int w = 0; w < 16; w++) blk_r[32*w +: 32] = $urandom;
            st_r = {$urandom, $urandom, $urandom, $urandom};
            if (k == 0) begin blk_r = '0; st_r = '0; end
            if (k == 1) begin blk_r = '1; st_r = '1; end
            run_block(st_r, blk_r, ref_compress(st_r, blk_r), "R2 random");
        end
        wait_idle();

        // R6: start pulses mid-run are ignored
        for (int w = 0; w < 16; w++) blk_r[32*w +: 32] = $urandom;
        for (int w = 0; w < 16; w++) blk_a2[32*w +: 32] = $urandom;
        st_r = {$urandom, $urandom, $urandom, $urandom};
        run_block(st_r, blk_r, ref_compress(st_r, blk_r), "R6 ignore mid-run start");
        repeat (10) @(negedge clk);
        state_in = IV; block_in = blk_a2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R7: output holds after done with start low
        hold_v = state_out;
        repeat (12) @(negedge clk);
        check(state_out === hold_v, "R7 hold after done", state_out, hold_v);
        check(busy === 1'b0, "R6 no restart from ignored start", {127'b0, busy}, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R4 run did not complete actual=%h expected=%h", 128'd0, 128'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule